// File: doc/BRIEF.md
# Programmable Countdown Timer with On-Demand Count Capture

This block is a single-channel down-counter that software controls through a small register interface. Each register has its own write strobe. There is a start value, a restart value, a run flag, an event-enable flag, a pending-clear strobe and a capture strobe. All of them share one write-data bus. While the run flag is low, the counter holds the start value. Once the run flag is set, it counts down by one each clock. When it reaches zero it either parks there or jumps to the restart value, depending on whether the restart value is zero.

Software does not see the live count. A capture strobe copies the count into a holding register, and software reads that register on the following cycle. Each entry into zero produces a single-cycle event pulse. The pulse sets a sticky pending flag, and that flag, gated by the event-enable flag, forms the interrupt line.

No data streams through this block, so it has no valid/ready pair. Every strobe is accepted on the clock edge where it is high, and there is no back-pressure.

Top module: `countdown_timer`

## Requirements
- R1: After reset the captured count, the event pulse, the pending flag and the interrupt are all 0, and all registers hold 0.
- R2: While the run flag is low, the counter takes the start value one clock after that value is written, and it stays there.
- R3: While the run flag is high and the count is nonzero, the count drops by exactly one on every clock edge.
- R4: With a restart value of zero, the counter stays at zero once it reaches zero, and it produces one event pulse per run.
- R5: With a nonzero restart value, the counter is at zero for one cycle and then takes the restart value on the next edge. This also holds when the start value is zero, in which case the first event comes in the cycle right after the run flag is set.
- R6: The captured count changes only on a clock edge where the capture strobe is high. It then holds the count from just before that edge, visible in the next cycle.
- R7: The event pulse is high for exactly one cycle each time the running counter enters zero. It is never high while the run flag is low. With a start value of 25, it rises 25 cycles after the edge that sets the run flag.
- R8: The pending flag is set by the event pulse and stays set until the clear strobe is written with bit 0 equal to 1. If an event and a clear occur in the same cycle, the event wins.
- R9: The interrupt equals the pending flag ANDed with the event-enable flag. Turning the enable off hides the interrupt without changing the pending flag.
- R10: Writing the run flag low stops the count. One edge later the counter returns to the start value, and it does not move while the flag stays low.
- R11: The run flag, the event-enable flag and the clear action use bit 0 of the write data only. For example, writing 2 to the run flag clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | W (32) | Write data shared by all strobes |
| wr_start | input | 1 | Write strobe for the start value |
| wr_restart | input | 1 | Write strobe for the restart value |
| wr_run | input | 1 | Write strobe for the run flag (bit 0) |
| wr_evt_en | input | 1 | Write strobe for the event-enable flag (bit 0) |
| wr_evt_clr | input | 1 | Clear strobe for the pending flag (acts when bit 0 is 1) |
| wr_capture | input | 1 | Capture strobe: copies the live count into the holding register |
| capture_value | output | W (32) | Captured count |
| zero_evt | output | 1 | One-cycle pulse on entry into zero |
| evt_pending | output | 1 | Sticky pending flag |
| irq | output | 1 | Interrupt: pending AND event enable |

## Verification
The bench measures the exact distance from setting the run flag to the event pulse. A design with an extra or a missing pipeline stage would fire one cycle early or late. The periodic run starts from a start value of zero, so a design that only restarts after a nonzero count, or that fires only on a 1-to-0 step, would miss the first event or lose the period. The bench also clears the pending flag with bit 0 low, and writes the run flag with only bit 1 set, to catch decoders that look at the whole word. It also forces an event and a clear into the same cycle, where a design with the wrong priority would drop the interrupt.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned CDT_DEFAULT_W = 32;

  typedef enum logic [1:0] {
    CNT_START   = 2'd0,
    CNT_DEC     = 2'd1,
    CNT_RESTART = 2'd2,
    CNT_PARK    = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wdata,
  input  logic         wr_start,
  input  logic         wr_restart,
  input  logic         wr_run,
  input  logic         wr_evt_en,
  output logic [W-1:0] start_q,
  output logic [W-1:0] restart_q,
  output logic         run_q,
  output logic         evt_en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      restart_q <= '0;
      run_q     <= 1'b0;
      evt_en_q  <= 1'b0;
    end else begin
      if (wr_start)   start_q   <= wdata;
      if (wr_restart) restart_q <= wdata;
      if (wr_run)     run_q     <= wdata[0];
      if (wr_evt_en)  evt_en_q  <= wdata[0];
    end
  end
endmodule

// File: rtl/cdt_core.sv
module cdt_core
  import cdt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] restart_val,
  output logic [W-1:0] cnt_q,
  output logic         at_zero
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  cnt_act_e     act;
  logic [W-1:0] cnt_d;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    if (!run)                      act = CNT_START;
    else if (!at_zero)             act = CNT_DEC;
    else if (restart_val != '0)    act = CNT_RESTART;
    else                           act = CNT_PARK;
  end

  always_comb begin
    unique case (act)
      CNT_START:   cnt_d = start_val;
      CNT_DEC:     cnt_d = cnt_q - ONE;
      CNT_RESTART: cnt_d = restart_val;
      default:     cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cdt_capture.sv
module cdt_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] live,
  output logic [W-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (take) held <= live;
  end
endmodule

// File: rtl/cdt_event.sv
module cdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic at_zero,
  input  logic evt_en,
  input  logic clr_req,
  output logic zero_evt,
  output logic pending,
  output logic irq
);
  logic was_zero_q;

  assign zero_evt = run && at_zero && !was_zero_q;
  assign irq      = pending && evt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_zero_q <= 1'b0;
      pending    <= 1'b0;
    end else begin
      was_zero_q <= run && at_zero;
      if (zero_evt)     pending <= 1'b1;
      else if (clr_req) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import cdt_pkg::*;
#(
  parameter int unsigned W = CDT_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wdata,
  input  logic         wr_start,
  input  logic         wr_restart,
  input  logic         wr_run,
  input  logic         wr_evt_en,
  input  logic         wr_evt_clr,
  input  logic         wr_capture,
  output logic [W-1:0] capture_value,
  output logic         zero_evt,
  output logic         evt_pending,
  output logic         irq
);
  logic [W-1:0] start_q, restart_q, cnt_q;
  logic         run_q, evt_en_q, at_zero;

  cdt_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .wr_start(wr_start), .wr_restart(wr_restart),
    .wr_run(wr_run), .wr_evt_en(wr_evt_en),
    .start_q(start_q), .restart_q(restart_q),
    .run_q(run_q), .evt_en_q(evt_en_q)
  );

  cdt_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .start_val(start_q), .restart_val(restart_q),
    .cnt_q(cnt_q), .at_zero(at_zero)
  );

  cdt_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(wr_capture),
    .live(cnt_q), .held(capture_value)
  );

  cdt_event u_evt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .at_zero(at_zero),
    .evt_en(evt_en_q), .clr_req(wr_evt_clr && wdata[0]),
    .zero_evt(zero_evt), .pending(evt_pending), .irq(irq)
  );
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_bit,
  input logic         wr_evt_clr,
  input logic         wr_run,
  input logic         wr_capture,
  input logic [W-1:0] capture_value,
  input logic         zero_evt,
  input logic         evt_pending,
  input logic         irq,
  input logic         run_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] restart_q
);
  p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_pending);

  p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pending && !(wr_evt_clr && clr_bit)) |=> evt_pending);

  p_evt_sets_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> evt_pending);

  p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> !zero_evt);

  p_evt_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> run_q);

  p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_capture |=> $stable(capture_value));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !wr_run) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_park_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == '0 && restart_q == '0 && !wr_run) |=> (cnt_q == '0));
endmodule

bind countdown_timer cdt_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_bit(wdata[0]), .wr_evt_clr(wr_evt_clr),
  .wr_run(wr_run), .wr_capture(wr_capture), .capture_value(capture_value),
  .zero_evt(zero_evt), .evt_pending(evt_pending), .irq(irq),
  .run_q(run_q), .cnt_q(cnt_q), .restart_q(restart_q)
);

// File: tb/tb_countdown_timer.sv
`timescale 1ns/1ps
module tb_countdown_timer;
  localparam int W = 32;
  localparam int S_START = 0, S_RESTART = 1, S_RUN = 2, S_EVTEN = 3,
                 S_CLR = 4, S_CAP = 5, S_NONE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] wdata = '0;
  logic wr_start = 0, wr_restart = 0, wr_run = 0, wr_evt_en = 0,
        wr_evt_clr = 0, wr_capture = 0;
  logic [W-1:0] capture_value;
  logic zero_evt, evt_pending, irq;

  always #5 clk = ~clk;

  countdown_timer dut (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .wr_start(wr_start), .wr_restart(wr_restart), .wr_run(wr_run),
    .wr_evt_en(wr_evt_en), .wr_evt_clr(wr_evt_clr), .wr_capture(wr_capture),
    .capture_value(capture_value), .zero_evt(zero_evt),
    .evt_pending(evt_pending), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, cycles = 0, evt_seen = 0;

  // Reference state built from the requirements
  logic [W-1:0] m_start, m_restart, m_cnt, m_cap;
  logic m_run, m_een, m_was, m_pend;

  function automatic logic exp_evt();
    return m_run && (m_cnt == '0) && !m_was;
  endfunction

  function automatic logic [W-1:0] next_cnt();
    if (!m_run)              return m_start;
    else if (m_cnt != '0)    return m_cnt - 1;
    else if (m_restart != 0) return m_restart;
    else                     return m_cnt;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = '0; m_restart = '0; m_cnt = '0; m_cap = '0;
      m_run = 0; m_een = 0; m_was = 0; m_pend = 0;
    end else begin
      logic ev;
      logic [W-1:0] nc;
      ev = exp_evt();
      nc = next_cnt();
      m_was  = m_run && (m_cnt == '0);
      m_pend = ev | (m_pend & !(wr_evt_clr & wdata[0]));
      if (wr_capture) m_cap = m_cnt;
      m_cnt = nc;
      if (wr_start)   m_start   = wdata;
      if (wr_restart) m_restart = wdata;
      if (wr_run)     m_run     = wdata[0];
      if (wr_evt_en)  m_een     = wdata[0];
    end
  end

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    if (zero_evt) evt_seen++;
    chk(capture_value == m_cap, "R6 capture", capture_value, m_cap);
    chk(zero_evt == exp_evt(), "R7 zero event", W'(zero_evt), W'(exp_evt()));
    chk(evt_pending == m_pend, "R8 pending", W'(evt_pending), W'(m_pend));
    chk(irq == (m_pend && m_een), "R9 irq", W'(irq), W'(m_pend && m_een));
  endtask

  task automatic bus_wr(input int sel, input logic [W-1:0] v);
    wdata = v;
    case (sel)
      S_START:   wr_start   = 1;
      S_RESTART: wr_restart = 1;
      S_RUN:     wr_run     = 1;
      S_EVTEN:   wr_evt_en  = 1;
      S_CLR:     wr_evt_clr = 1;
      S_CAP:     wr_capture = 1;
      default: ;
    endcase
    tick();
    {wr_start, wr_restart, wr_run, wr_evt_en, wr_evt_clr, wr_capture} = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h1BADCAFE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(capture_value == 0, "R1 capture after reset", capture_value, 0);
    chk({zero_evt, evt_pending, irq} == 3'b000, "R1 flags after reset",
        W'({zero_evt, evt_pending, irq}), 0);

    // R2 start value followed while stopped
    bus_wr(S_START, 100); idle(1); bus_wr(S_CAP, 0);
    chk(capture_value == 100, "R2 follows start value", capture_value, 100);
    bus_wr(S_START, 7); idle(1); bus_wr(S_CAP, 0);
    chk(capture_value == 7, "R2 follows new start value", capture_value, 7);

    // R3 decrement by one per cycle
    bus_wr(S_RUN, 1); idle(3); bus_wr(S_CAP, 0);
    chk(capture_value == 4, "R3 count after 3 cycles", capture_value, 4);
    idle(2);
    chk(capture_value == 4, "R6 capture holds without strobe", capture_value, 4);

    // R4 one-shot
    bus_wr(S_RUN, 0); bus_wr(S_START, 5); bus_wr(S_RESTART, 0); idle(1);
    evt_seen = 0;
    bus_wr(S_RUN, 1); idle(20); bus_wr(S_CAP, 0);
    chk(capture_value == 0, "R4 parks at zero", capture_value, 0);
    chk(evt_seen == 1, "R4 single event per run", evt_seen, 1);
    idle(5); bus_wr(S_CAP, 0);
    chk(capture_value == 0, "R4 still zero", capture_value, 0);

    // R7 event latency with start value 25
    bus_wr(S_RUN, 0); bus_wr(S_START, 25); bus_wr(S_EVTEN, 1);
    bus_wr(S_CLR, 1); idle(1);
    chk(!zero_evt && !evt_pending, "R7 no event before run",
        W'({zero_evt, evt_pending}), 0);
    bus_wr(S_RUN, 1);
    k = 0;
    for (int i = 1; i <= 40 && k == 0; i++) begin
      tick();
      if (zero_evt) k = i;
    end
    chk(k == 25, "R7 event latency", k, 25);
    idle(1);
    chk(irq == 1, "R9 irq with enable", irq, 1);
    bus_wr(S_EVTEN, 0);
    chk(irq == 0 && evt_pending == 1, "R9 enable masks irq only",
        W'({irq, evt_pending}), 1);
    bus_wr(S_CLR, 2);
    chk(evt_pending == 1, "R11 clear ignores bit 1", evt_pending, 1);
    bus_wr(S_CLR, 1);
    chk(evt_pending == 0, "R8 clear with bit 0", evt_pending, 0);

    // R5 periodic from start value zero
    bus_wr(S_RUN, 0); bus_wr(S_START, 0); bus_wr(S_RESTART, 3); idle(1);
    evt_seen = 0;
    bus_wr(S_RUN, 1);
    chk(evt_seen == 1, "R5 immediate event from zero start", evt_seen, 1);
    idle(8);
    chk(evt_seen == 3, "R5 periodic events", evt_seen, 3);
    idle(1); bus_wr(S_CAP, 0);
    chk(capture_value == 3, "R5 restart value loaded", capture_value, 3);

    // R8 event and clear in same cycle: restart=1 gives event every 2 cycles
    bus_wr(S_RESTART, 1);
    k = 0;
    for (int i = 0; i < 6 && k == 0; i++) begin
      if (exp_evt()) k = 1; else tick();
    end
    bus_wr(S_CLR, 1);
    chk(evt_pending == 1, "R8 event wins over clear", evt_pending, 1);

    // R10 stopping returns to start value
    bus_wr(S_RUN, 0); bus_wr(S_START, 50); bus_wr(S_RESTART, 0); idle(1);
    bus_wr(S_RUN, 1); idle(5); bus_wr(S_RUN, 0); idle(1); bus_wr(S_CAP, 0);
    chk(capture_value == 50, "R10 back to start value", capture_value, 50);
    idle(10); bus_wr(S_CAP, 0);
    chk(capture_value == 50, "R10 frozen while stopped", capture_value, 50);

    // R11 run flag uses bit 0 only
    bus_wr(S_START, 9); idle(1); bus_wr(S_RUN, 1); idle(2);
    bus_wr(S_RUN, 32'h2); idle(3); bus_wr(S_CAP, 0);
    chk(capture_value == 9, "R11 run write of 2 stops", capture_value, 9);

    // Random traffic against the reference state
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 4)       bus_wr(S_START, $urandom % 13);
      else if (r < 8)  bus_wr(S_RESTART, $urandom % 13);
      else if (r < 11) bus_wr(S_RUN, ($urandom % 4 != 0) ? W'($urandom % 4 | 1) : W'(2));
      else if (r < 14) bus_wr(S_EVTEN, $urandom % 2);
      else if (r < 24) bus_wr(S_CLR, $urandom % 4);
      else if (r < 44) bus_wr(S_CAP, $urandom);
      else             tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule